// File: doc/BRIEF.md
# Operate-Group Micro-Action Unit

This unit carries out the operate instruction of a word-oriented processor. It works on three pieces of state: a 36-bit ones'-complement accumulator, a 36-bit in-out register and six program flags. The address field of an operate instruction is not a memory address. Each of its high bits asks for one independent micro-action: clear the in-out register, clear the accumulator, merge the console test-word switches into the accumulator, complement the accumulator, or request a halt. The low four bits give a set-or-clear command for one program flag, or for all of them.

Any mix of the high bits may appear in one word, and all of them take effect in a single clock. The accumulator actions always run in a fixed order inside that clock, so that a clear together with a merge loads the switch word exactly. The instruction decoder presents each instruction as a one-cycle strobe with its opcode and address field. Other parts of the datapath can write the in-out register through a load port. The new register values and a one-cycle halt request appear on the clock edge after the strobe.

Top module: `opr_unit`

## Requirements
- R1: After reset the accumulator, the in-out register and all flags read zero, and the halt request is low.
- R2: A cycle without a strobe, or a strobe whose opcode is not 76 octal, leaves the accumulator and the flags unchanged and raises no halt request. The in-out register changes in such a cycle only through its load port.
- R3: An operate instruction with address bit 11 (octal 4000) set makes the in-out register read zero on the next edge.
- R4: Address bit 7 (octal 200) clears the accumulator to plus zero, which is all bits zero.
- R5: Address bit 10 (octal 2000) replaces the accumulator with its bitwise OR with the test-word switches.
- R6: Address bit 9 (octal 1000) replaces the accumulator with its bitwise complement, which is its ones'-complement negative.
- R7: Within one instruction the clear is applied first, then the OR, then the complement. So 2200 octal loads the test word and 3200 octal loads its complement.
- R8: Address bit 8 (octal 400) drives the halt request high for exactly the one cycle after the instruction.
- R9: Address bits 2..0 select a flag. Value 0 selects none, value k from 1 to 6 selects flag k (bit k-1 of the flag output), and value 7 selects all six. Address bit 3 (octal 10) sets the selected flags when it is one and clears them when it is zero. Flags that are not selected keep their value.
- R10: The load port writes the in-out register on the next edge. If an operate instruction with bit 11 is strobed in the same cycle, the clear wins and the register reads zero.
- R11: All micro-actions requested in one address field take effect together on the same edge, including the flag command, the in-out clear and the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | One-cycle strobe for a decoded instruction |
| instr_opcode | input | 6 | Opcode of the strobed instruction |
| instr_addr | input | 12 | Address field, read here as micro-action bits |
| test_word | input | 36 | Console test-word switch value |
| io_ld | input | 1 | Write strobe for the in-out register from the datapath |
| io_ld_data | input | 36 | Value for the in-out register write |
| ac | output | 36 | Accumulator |
| io_reg | output | 36 | In-out register |
| flags | output | 6 | Program flags, flag k at bit k-1 |
| halt_req | output | 1 | One-cycle halt request |

## Verification
Two sets of functions can land on the same edge. One is a datapath load of the in-out register together with an operate word that clears it. The other is the accumulator clear, OR and complement inside one word. The bench drives both. It sends a load strobe in the same cycle as a 4000 octal instruction and expects zero. It sends words such as 3200, 2200 and 7617 octal and expects the complement of the switch word, the exact switch word, and every other side effect all after one edge. A behavioural reference model runs beside the unit and is compared with it on every clock. Directed checks on fixed constants confirm the accumulator ordering.

// File: rtl/opr_pkg.sv
package opr_pkg;

    // Instruction format: the address field width and micro-action bit
    // positions are fixed by the instruction word.
    localparam int ADDR_W     = 12;
    localparam int FSEL_W     = 3;
    localparam int BIT_IO_CLR = 11;   // 4000 octal
    localparam int BIT_AC_OR  = 10;   // 2000 octal
    localparam int BIT_AC_CMP = 9;    // 1000 octal
    localparam int BIT_HALT   = 8;    // 0400 octal
    localparam int BIT_AC_CLR = 7;    // 0200 octal
    localparam int BIT_F_SET  = 3;    // 0010 octal
    localparam logic [FSEL_W-1:0] FSEL_NONE = '0;
    localparam logic [FSEL_W-1:0] FSEL_ALL  = '1;

    // Decoded micro-actions of one operate word.
    typedef struct packed {
        logic              hit;
        logic              io_clr;
        logic              ac_clr;
        logic              ac_or;
        logic              ac_cmp;
        logic              halt;
        logic              f_set;
        logic [FSEL_W-1:0] f_sel;
    } uop_t;

endpackage

// File: rtl/opr_decode.sv
module opr_decode
    import opr_pkg::*;
#(
    parameter int               OPC_W   = 6,
    parameter logic [OPC_W-1:0] OPC_OPR = 6'o76
) (
    input  logic              valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [ADDR_W-1:0] addr,
    output uop_t              uop
);

    logic hit;

    always_comb begin
        hit        = valid && (opcode == OPC_OPR);
        uop        = '0;
        uop.hit    = hit;
        uop.io_clr = hit && addr[BIT_IO_CLR];
        uop.ac_clr = hit && addr[BIT_AC_CLR];
        uop.ac_or  = hit && addr[BIT_AC_OR];
        uop.ac_cmp = hit && addr[BIT_AC_CMP];
        uop.halt   = hit && addr[BIT_HALT];
        uop.f_set  = addr[BIT_F_SET];
        uop.f_sel  = hit ? addr[FSEL_W-1:0] : FSEL_NONE;
    end

endmodule

// File: rtl/opr_acc_path.sv
module opr_acc_path
    import opr_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic [WORD_W-1:0] ac_in,
    input  logic [WORD_W-1:0] tword,
    input  uop_t              uop,
    output logic [WORD_W-1:0] ac_out
);

    // Three stages in fixed order: clear, merge, complement.
    localparam int NSTAGE = 3;

    logic [WORD_W-1:0] stage [NSTAGE+1];

    assign stage[0] = ac_in;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        if (s == 0) begin : g_clr
            assign stage[s+1] = uop.ac_clr ? '0 : stage[s];
        end else if (s == 1) begin : g_or
            assign stage[s+1] = uop.ac_or ? (stage[s] | tword) : stage[s];
        end else begin : g_cmp
            assign stage[s+1] = uop.ac_cmp ? ~stage[s] : stage[s];
        end
    end

    assign ac_out = stage[NSTAGE];

endmodule

// File: rtl/opr_flag_unit.sv
module opr_flag_unit
    import opr_pkg::*;
#(
    parameter int NFLAGS = 6
) (
    input  logic [NFLAGS-1:0] flags_in,
    input  uop_t              uop,
    output logic [NFLAGS-1:0] flags_out
);

    for (genvar k = 0; k < NFLAGS; k++) begin : g_flag
        localparam logic [FSEL_W-1:0] MY_CODE = FSEL_W'(k + 1);
        logic picked;
        assign picked       = (uop.f_sel == FSEL_ALL) || (uop.f_sel == MY_CODE);
        assign flags_out[k] = picked ? uop.f_set : flags_in[k];
    end

endmodule

// File: rtl/opr_unit.sv
module opr_unit
    import opr_pkg::*;
#(
    parameter int               WORD_W  = 36,
    parameter int               NFLAGS  = 6,
    parameter int               OPC_W   = 6,
    parameter logic [OPC_W-1:0] OPC_OPR = 6'o76
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [OPC_W-1:0]   instr_opcode,
    input  logic [ADDR_W-1:0]  instr_addr,
    input  logic [WORD_W-1:0]  test_word,
    input  logic               io_ld,
    input  logic [WORD_W-1:0]  io_ld_data,
    output logic [WORD_W-1:0]  ac,
    output logic [WORD_W-1:0]  io_reg,
    output logic [NFLAGS-1:0]  flags,
    output logic               halt_req
);

    typedef struct packed {
        logic [WORD_W-1:0] ac;
        logic [WORD_W-1:0] io;
        logic [NFLAGS-1:0] flags;
        logic              halt;
    } state_t;

    uop_t              uop;
    logic [WORD_W-1:0] ac_nx;
    logic [NFLAGS-1:0] flags_nx;
    state_t            st_d;
    state_t            st_q;

    opr_decode #(
        .OPC_W   (OPC_W),
        .OPC_OPR (OPC_OPR)
    ) u_decode (
        .valid  (instr_valid),
        .opcode (instr_opcode),
        .addr   (instr_addr),
        .uop    (uop)
    );

    opr_acc_path #(
        .WORD_W (WORD_W)
    ) u_acc (
        .ac_in  (st_q.ac),
        .tword  (test_word),
        .uop    (uop),
        .ac_out (ac_nx)
    );

    opr_flag_unit #(
        .NFLAGS (NFLAGS)
    ) u_flags (
        .flags_in  (st_q.flags),
        .uop       (uop),
        .flags_out (flags_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ac    = ac_nx;
        st_d.flags = flags_nx;
        st_d.halt  = uop.halt;
        if (io_ld) begin
            st_d.io = io_ld_data;
        end
        if (uop.io_clr) begin
            st_d.io = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ac       = st_q.ac;
    assign io_reg   = st_q.io;
    assign flags    = st_q.flags;
    assign halt_req = st_q.halt;

endmodule

// File: rtl/opr_unit_chk.sv
module opr_unit_chk
    import opr_pkg::*;
#(
    parameter int               WORD_W  = 36,
    parameter int               NFLAGS  = 6,
    parameter int               OPC_W   = 6,
    parameter logic [OPC_W-1:0] OPC_OPR = 6'o76
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic [OPC_W-1:0]   instr_opcode,
    input logic [ADDR_W-1:0]  instr_addr,
    input logic [WORD_W-1:0]  test_word,
    input logic               io_ld,
    input logic [WORD_W-1:0]  io_ld_data,
    input logic [WORD_W-1:0]  ac,
    input logic [WORD_W-1:0]  io_reg,
    input logic [NFLAGS-1:0]  flags,
    input logic               halt_req
);

    logic opr_hit;
    assign opr_hit = instr_valid && (instr_opcode == OPC_OPR);

    // R2
    no_opr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !opr_hit |=> (ac == $past(ac)) && (flags == $past(flags)) && !halt_req);

    // R3
    io_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opr_hit && instr_addr[BIT_IO_CLR] |=> (io_reg == '0));

    // R4
    ac_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opr_hit && instr_addr[BIT_AC_CLR] && !instr_addr[BIT_AC_OR]
        && !instr_addr[BIT_AC_CMP] |=> (ac == '0));

    // R6
    ac_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opr_hit && instr_addr[BIT_AC_CMP] && !instr_addr[BIT_AC_CLR]
        && !instr_addr[BIT_AC_OR] |=> (ac == ~$past(ac)));

    // R7
    ac_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opr_hit && instr_addr[BIT_AC_CLR] && instr_addr[BIT_AC_OR]
        && !instr_addr[BIT_AC_CMP] |=> (ac == $past(test_word)));

    // R8
    halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $past(opr_hit && instr_addr[BIT_HALT]));

    // R9
    all_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opr_hit && (instr_addr[3:0] == 4'o17) |=> (flags == {NFLAGS{1'b1}}));

    // R10
    io_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_ld && !(opr_hit && instr_addr[BIT_IO_CLR]) |=> (io_reg == $past(io_ld_data)));

endmodule

bind opr_unit opr_unit_chk #(
    .WORD_W  (WORD_W),
    .NFLAGS  (NFLAGS),
    .OPC_W   (OPC_W),
    .OPC_OPR (OPC_OPR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr_opcode (instr_opcode),
    .instr_addr   (instr_addr),
    .test_word    (test_word),
    .io_ld        (io_ld),
    .io_ld_data   (io_ld_data),
    .ac           (ac),
    .io_reg       (io_reg),
    .flags        (flags),
    .halt_req     (halt_req)
);

// File: tb/opr_unit_bench.sv
`timescale 1ns/1ps
module opr_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [5:0]  instr_opcode = '0;
    logic [11:0] instr_addr = '0;
    logic [35:0] test_word = '0;
    logic        io_ld = 1'b0;
    logic [35:0] io_ld_data = '0;
    logic [35:0] ac;
    logic [35:0] io_reg;
    logic [5:0]  flags;
    logic        halt_req;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // reference model state
    logic [35:0] m_ac, m_io;
    logic [5:0]  m_fl;
    logic        m_halt;

    always #2.5 clk = ~clk;

    opr_unit u_opr_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_valid  (instr_valid),
        .instr_opcode (instr_opcode),
        .instr_addr   (instr_addr),
        .test_word    (test_word),
        .io_ld        (io_ld),
        .io_ld_data   (io_ld_data),
        .ac           (ac),
        .io_reg       (io_reg),
        .flags        (flags),
        .halt_req     (halt_req)
    );

    // Behavioural reference: one instruction per edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ac <= '0; m_io <= '0; m_fl <= '0; m_halt <= 1'b0;
        end else begin
            automatic logic [35:0] a = m_ac;
            automatic logic [35:0] io = m_io;
            automatic logic [5:0]  f = m_fl;
            automatic logic [5:0]  mask = '0;
            automatic bit          is_opr = instr_valid && (instr_opcode == 6'o76);
            if (io_ld) io = io_ld_data;
            if (is_opr) begin
                if (instr_addr & 12'o0200) a = 36'd0;
                if (instr_addr & 12'o2000) a = a | test_word;
                if (instr_addr & 12'o1000) a = ~a;
                if (instr_addr & 12'o4000) io = 36'd0;
                case (instr_addr & 12'o7)
                    12'o0:   mask = 6'b000000;
                    12'o7:   mask = 6'b111111;
                    default: mask = 6'(1 << ((instr_addr & 12'o7) - 1));
                endcase
                if (instr_addr & 12'o10) f = f | mask;
                else                     f = f & ~mask;
            end
            m_ac   <= a;
            m_io   <= io;
            m_fl   <= f;
            m_halt <= is_opr && ((instr_addr & 12'o400) != 0);
        end
    end

    task automatic compare_all();
        n_checks++;
        if (ac !== m_ac || io_reg !== m_io || flags !== m_fl || halt_req !== m_halt) begin
            n_fail++;
            $display("FAIL %s: actual ac=%o io=%o flags=%b halt=%b expected ac=%o io=%o flags=%b halt=%b",
                     cur_req, ac, io_reg, flags, halt_req, m_ac, m_io, m_fl, m_halt);
        end
    endtask

    task automatic expect36(input logic [35:0] act, input logic [35:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %o expected %o", req, act, exp);
        end
    endtask

    task automatic expect6(input logic [5:0] act, input logic [5:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [5:0] opc, input logic [11:0] a,
                        input logic [35:0] tw, input logic ld, input logic [35:0] ldd,
                        input string req);
        @(negedge clk);
        instr_valid = v; instr_opcode = opc; instr_addr = a;
        test_word = tw; io_ld = ld; io_ld_data = ldd; cur_req = req;
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic opr(input logic [11:0] a, input logic [35:0] tw, input string req);
        step(1'b1, 6'o76, a, tw, 1'b0, '0, req);
    endtask

    task automatic idle(input string req);
        step(1'b0, 6'o76, 12'o0, '0, 1'b0, '0, req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        expect36(ac, '0, "R1");
        expect36(io_reg, '0, "R1");
        expect6(flags, '0, "R1");
        expect6({5'd0, halt_req}, '0, "R1");
        @(negedge clk); rst_n = 1'b1;

        // R5 OR test word
        opr(12'o2000, 36'o123456701234, "R5");
        expect36(ac, 36'o123456701234, "R5");
        opr(12'o2000, 36'o400000000001, "R5");
        expect36(ac, 36'o523456701235, "R5");
        // R6 complement
        opr(12'o1000, '0, "R6");
        expect36(ac, 36'o254321076542, "R6");
        // R4 clear
        opr(12'o0200, 36'o777, "R4");
        expect36(ac, '0, "R4");
        // R7 ordering
        opr(12'o2200, 36'o707070707070, "R7");
        expect36(ac, 36'o707070707070, "R7");
        opr(12'o3200, 36'o000011112222, "R7");
        expect36(ac, 36'o777766665555, "R7");
        opr(12'o3000, 36'o000000000003, "R7");
        expect36(ac, 36'o000011112220, "R7");

        // R10 load then R3 clear
        step(1'b0, 6'o00, 12'o0, '0, 1'b1, 36'o111122223333, "R10");
        expect36(io_reg, 36'o111122223333, "R10");
        opr(12'o4000, '0, "R3");
        expect36(io_reg, '0, "R3");
        step(1'b1, 6'o76, 12'o4000, '0, 1'b1, 36'o555555555555, "R10");
        expect36(io_reg, '0, "R10");
        step(1'b1, 6'o74, 12'o4000, '0, 1'b1, 36'o246, "R10");
        expect36(io_reg, 36'o246, "R10");

        // R9 flags: set each, clear each, all, none
        for (int k = 1; k <= 6; k++) begin
            opr(12'(8 + k), '0, "R9");
        end
        expect6(flags, 6'b111111, "R9");
        opr(12'o03, '0, "R9");
        expect6(flags, 6'b111011, "R9");
        opr(12'o00, '0, "R9");
        expect6(flags, 6'b111011, "R9");
        opr(12'o10, '0, "R9");
        expect6(flags, 6'b111011, "R9");
        opr(12'o07, '0, "R9");
        expect6(flags, 6'b000000, "R9");
        opr(12'o16, '0, "R9");
        expect6(flags, 6'b100000, "R9");
        opr(12'o17, '0, "R9");
        expect6(flags, 6'b111111, "R9");
        opr(12'o01, '0, "R9");
        expect6(flags, 6'b111110, "R9");

        // R8 halt pulse
        opr(12'o0400, '0, "R8");
        expect6({5'd0, halt_req}, 6'd1, "R8");
        idle("R8");
        expect6({5'd0, halt_req}, 6'd0, "R8");

        // R2 other opcodes and no strobe
        step(1'b1, 6'o74, 12'o7777, 36'o7, 1'b0, '0, "R2");
        expect6(flags, 6'b111110, "R2");
        expect6({5'd0, halt_req}, 6'd0, "R2");
        step(1'b0, 6'o76, 12'o7607, 36'o7, 1'b0, '0, "R2");
        expect36(ac, 36'o000011112220, "R2");

        // R11 everything in one word
        step(1'b0, 6'o00, 12'o0, '0, 1'b1, 36'o1, "R11");
        opr(12'o7617, 36'o000000007777, "R11");
        expect36(ac, 36'o777777770000, "R11");
        expect36(io_reg, '0, "R11");
        expect6(flags, 6'b111111, "R11");
        expect6({5'd0, halt_req}, 6'd1, "R11");
        opr(12'o1207, '0, "R11");
        expect36(ac, 36'o777777777777, "R11");
        expect6(flags, 6'b000000, "R11");

        for (int i = 0; i < 4; i++) idle("R2");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule